// File: doc/BRIEF.md
# Instruction Machine-Cycle Timing Sequencer

This block paces a single instruction through its bus machine cycles, one T-state per clock. A decoder in front of it supplies a two-bit instruction class together with a one-clock start request. The sequencer then runs an opcode-fetch cycle, followed by whatever the class needs: nothing more, one memory read, or a run of bus-idle cycles. On every clock it reports which machine cycle and which T-state is active. It also drives the address-latch strobe, the read strobe, a program-counter advance pulse and an address-source select.

A register-operand instruction takes 4 T-states. A memory-operand instruction and an immediate instruction each take 7. The 16-bit register-pair add takes 10, because it spends two machine cycles with the bus idle while the wide sum is formed internally. On the final T-state the block raises `done` for one clock. It accepts a new start only once it has returned to idle.

Top module: `instr_cycle_seq`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `mcycle`=0, `tstate`=0, and `ale`, `rd_stb`, `pc_inc`, `addr_hl`, `busy` and `done` are all 0.
- R2: Class 0 (register operand) runs one opcode-fetch cycle (`mcycle`=1) with `tstate` 1,2,3,4, then ends. That is 4 T-states in total.
- R3: Class 1 (memory operand) runs a fetch of 4 T-states and then a read cycle (`mcycle`=2) with `tstate` 1,2,3, for 7 in total. `addr_hl` is 1 during every T-state of that read cycle and 0 at all other times.
- R4: Class 2 (immediate) runs a fetch of 4 T-states and then a read cycle of 3, for 7 in total, with `addr_hl` held at 0. `pc_inc` pulses exactly twice: in T2 of the fetch and in T2 of the read.
- R5: Class 3 (16-bit add) runs a fetch of 4 T-states and then two bus-idle cycles (`mcycle`=3) of 3 T-states each, for 10 in total.
- R6: In a bus-idle cycle, `ale`, `rd_stb` and `pc_inc` all stay 0.
- R7: `ale` is 1 only in T1 of a fetch or read cycle. `rd_stb` is 1 only in T2 and T3 of a fetch or read cycle.
- R8: `pc_inc` is 1 in T2 of every fetch cycle and never during an HL-addressed read.
- R9: `done` is 1 for exactly one clock, on the final T-state of the instruction. On the following clock `busy`=0 and `mcycle`=0.
- R10: A start request seen while `busy`=1 is ignored, and the running instruction's timing is unchanged.
- R11: Pulling `rst_n` low in the middle of an instruction returns the block to idle at once, with all strobes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period is one T-state |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Start request, sampled while idle |
| iclass | input | 2 | Instruction class: 0 register, 1 memory, 2 immediate, 3 16-bit add |
| mcycle | output | 2 | Machine cycle: 0 none, 1 opcode fetch, 2 memory read, 3 bus idle |
| tstate | output | 3 | T-state within the machine cycle, counting from 1; 0 when idle |
| ale | output | 1 | Address-latch strobe |
| rd_stb | output | 1 | Read strobe |
| pc_inc | output | 1 | Program-counter advance pulse |
| addr_hl | output | 1 | Address source: 1 HL pair, 0 program counter |
| busy | output | 1 | An instruction is in progress |
| done | output | 1 | Final T-state of the instruction |

## Verification
Every output is decoded from registers only. T-state k of an instruction is therefore visible in the k-th clock after the edge that accepted `start`, and `done` appears in clock 4, 7 or 10. The bench raises `start` just after a falling edge. It then samples all outputs at each later falling edge, step k at the k-th one, and compares them with values it builds from the class alone. One extra falling edge confirms the return to idle. Asynchronous reset is checked 1 ns after `rst_n` falls, with no clock edge in between.

// File: rtl/ics_pkg.sv
package ics_pkg;
  typedef enum logic [1:0] {
    CLS_REG   = 2'd0,
    CLS_MEM   = 2'd1,
    CLS_IMM   = 2'd2,
    CLS_ADD16 = 2'd3
  } iclass_e;

  typedef enum logic [1:0] {
    MC_NONE  = 2'd0,
    MC_FETCH = 2'd1,
    MC_READ  = 2'd2,
    MC_IDLE  = 2'd3
  } mcyc_e;
endpackage

// File: rtl/ics_tstate_ctr.sv
module ics_tstate_ctr #(
  parameter int TW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          restart,
  input  logic [TW-1:0] len,
  output logic [TW-1:0] t_q,
  output logic          last_t
);
  logic [TW-1:0] t_nxt;
  logic          t_en;

  assign last_t = active && (t_q == len);

  always_comb begin
    t_nxt = t_q;
    if (restart)     t_nxt = TW'(1);
    else if (last_t) t_nxt = '0;
    else if (active) t_nxt = t_q + TW'(1);
  end

  assign t_en = restart | active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    t_q <= '0;
    else if (t_en) t_q <= t_nxt;
  end
endmodule

// File: rtl/ics_mcyc_ctrl.sv
module ics_mcyc_ctrl
  import ics_pkg::*;
#(
  parameter int IDLE_CYC = 2,
  parameter int CW       = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  iclass_e cls_in,
  input  logic    last_t,
  output mcyc_e   mc_q,
  output iclass_e cls_q,
  output logic    busy,
  output logic    restart,
  output logic    done
);
  mcyc_e         mc_nxt;
  iclass_e       cls_nxt;
  logic [CW-1:0] idle_q, idle_nxt;
  logic          ld_en;

  assign busy  = (mc_q != MC_NONE);
  assign ld_en = (!busy && start) || last_t;

  always_comb begin
    mc_nxt   = mc_q;
    cls_nxt  = cls_q;
    idle_nxt = idle_q;
    restart  = 1'b0;
    done     = 1'b0;
    if (!busy) begin
      if (start) begin
        mc_nxt   = MC_FETCH;
        cls_nxt  = cls_in;
        idle_nxt = CW'(IDLE_CYC);
        restart  = 1'b1;
      end
    end else if (last_t) begin
      unique case (mc_q)
        MC_FETCH: begin
          unique case (cls_q)
            CLS_REG:   mc_nxt = MC_NONE;
            CLS_ADD16: mc_nxt = MC_IDLE;
            default:   mc_nxt = MC_READ;
          endcase
        end
        MC_READ: mc_nxt = MC_NONE;
        MC_IDLE: begin
          idle_nxt = idle_q - CW'(1);
          mc_nxt   = (idle_q == CW'(1)) ? MC_NONE : MC_IDLE;
        end
        default: mc_nxt = MC_NONE;
      endcase
      restart = (mc_nxt != MC_NONE);
      done    = (mc_nxt == MC_NONE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mc_q   <= MC_NONE;
      cls_q  <= CLS_REG;
      idle_q <= '0;
    end else if (ld_en) begin
      mc_q   <= mc_nxt;
      cls_q  <= cls_nxt;
      idle_q <= idle_nxt;
    end
  end
endmodule

// File: rtl/ics_strobe_dec.sv
module ics_strobe_dec
  import ics_pkg::*;
#(
  parameter int TW = 3
) (
  input  mcyc_e         mc,
  input  iclass_e       cls,
  input  logic [TW-1:0] t,
  output logic          ale,
  output logic          rd_stb,
  output logic          pc_inc,
  output logic          addr_hl
);
  logic bus_cyc;

  always_comb begin
    bus_cyc = (mc == MC_FETCH) || (mc == MC_READ);
    ale     = bus_cyc && (t == TW'(1));
    rd_stb  = bus_cyc && ((t == TW'(2)) || (t == TW'(3)));
    pc_inc  = (t == TW'(2)) &&
              ((mc == MC_FETCH) || ((mc == MC_READ) && (cls == CLS_IMM)));
    addr_hl = (mc == MC_READ) && (cls == CLS_MEM);
  end
endmodule

// File: rtl/instr_cycle_seq.sv
module instr_cycle_seq
  import ics_pkg::*;
#(
  parameter int FETCH_T  = 4,
  parameter int ACCESS_T = 3,
  parameter int IDLE_CYC = 2,
  localparam int TW = $clog2(FETCH_T + 1),
  localparam int CW = $clog2(IDLE_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    iclass,
  output logic [1:0]    mcycle,
  output logic [TW-1:0] tstate,
  output logic          ale,
  output logic          rd_stb,
  output logic          pc_inc,
  output logic          addr_hl,
  output logic          busy,
  output logic          done
);
  mcyc_e         mc_q;
  iclass_e       cls_q;
  logic          restart, last_t;
  logic [TW-1:0] t_q, cyc_len;

  assign cyc_len = (mc_q == MC_FETCH) ? TW'(FETCH_T) : TW'(ACCESS_T);

  ics_mcyc_ctrl #(.IDLE_CYC(IDLE_CYC), .CW(CW)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .cls_in  (iclass_e'(iclass)),
    .last_t  (last_t),
    .mc_q    (mc_q),
    .cls_q   (cls_q),
    .busy    (busy),
    .restart (restart),
    .done    (done)
  );

  ics_tstate_ctr #(.TW(TW)) u_tctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (busy),
    .restart (restart),
    .len     (cyc_len),
    .t_q     (t_q),
    .last_t  (last_t)
  );

  ics_strobe_dec #(.TW(TW)) u_dec (
    .mc      (mc_q),
    .cls     (cls_q),
    .t       (t_q),
    .ale     (ale),
    .rd_stb  (rd_stb),
    .pc_inc  (pc_inc),
    .addr_hl (addr_hl)
  );

  assign mcycle = mc_q;
  assign tstate = t_q;
endmodule

// File: rtl/ics_checker.sv
module ics_checker #(
  parameter int TW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [1:0]    mcycle,
  input logic [TW-1:0] tstate,
  input logic          ale,
  input logic          rd_stb,
  input logic          pc_inc,
  input logic          addr_hl,
  input logic          busy,
  input logic          done
);
  assert_start_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (mcycle == 2'd1 && tstate == TW'(1)));

  assert_hl_read_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    addr_hl |-> (mcycle == 2'd2 && !pc_inc));

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mcycle == 2'd3) |-> (!ale && !rd_stb && !pc_inc));

  assert_ale_t1_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (tstate == TW'(1) && (mcycle == 2'd1 || mcycle == 2'd2)));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
endmodule

bind instr_cycle_seq ics_checker #(.TW(TW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .mcycle  (mcycle),
  .tstate  (tstate),
  .ale     (ale),
  .rd_stb  (rd_stb),
  .pc_inc  (pc_inc),
  .addr_hl (addr_hl),
  .busy    (busy),
  .done    (done)
);

// File: tb/tb_instr_cycle_seq.sv
`timescale 1ns/100ps
module tb_instr_cycle_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [1:0] iclass = 2'd0;
  logic [1:0] mcycle;
  logic [2:0] tstate;
  logic       ale, rd_stb, pc_inc, addr_hl, busy, done;
  int         total = 0;
  int         bad = 0;

  always #2.5 clk = ~clk;

  instr_cycle_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .iclass(iclass),
    .mcycle(mcycle), .tstate(tstate), .ale(ale), .rd_stb(rd_stb),
    .pc_inc(pc_inc), .addr_hl(addr_hl), .busy(busy), .done(done)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_idle(input string req);
    check(req, "mcycle", mcycle, 0);
    check(req, "tstate", tstate, 0);
    check(req, "strobes", {ale, rd_stb, pc_inc, addr_hl, busy, done}, 0);
  endtask

  // one instruction of class cls; hold keeps start high throughout (R10)
  task automatic run_instr(input logic [1:0] cls, input bit hold);
    int    n;
    int    pulses;
    string rq;
    n      = (cls == 2'd0) ? 4 : (cls == 2'd3) ? 10 : 7;
    rq     = (cls == 2'd0) ? "R2" : (cls == 2'd1) ? "R3" : (cls == 2'd2) ? "R4" : "R5";
    if (hold) rq = "R10";
    pulses = 0;
    @(negedge clk);
    iclass = cls;
    start  = 1'b1;
    for (int s = 1; s <= n; s++) begin
      int em, et;
      bit bus, e_ale, e_rd, e_pc, e_hl;
      @(negedge clk);
      if (!hold) start = 1'b0;
      if (s <= 4) begin em = 1; et = s; end
      else begin em = (cls == 2'd3) ? 3 : 2; et = ((s - 5) % 3) + 1; end
      bus   = (em == 1) || (em == 2);
      e_ale = bus && et == 1;
      e_rd  = bus && (et == 2 || et == 3);
      e_pc  = (et == 2) && (em == 1 || (em == 2 && cls == 2'd2));
      e_hl  = (em == 2) && (cls == 2'd1);
      check(rq, "mcycle", mcycle, em);
      check(rq, "tstate", tstate, et);
      check((em == 3) ? "R6" : "R7", "ale", ale, e_ale);
      check((em == 3) ? "R6" : "R7", "rd_stb", rd_stb, e_rd);
      check((em == 3) ? "R6" : "R8", "pc_inc", pc_inc, e_pc);
      check("R3", "addr_hl", addr_hl, e_hl);
      check("R9", "done", done, (s == n) ? 1 : 0);
      if (pc_inc) pulses++;
    end
    @(negedge clk);
    start = 1'b0;
    check_idle("R9");
    check((cls == 2'd2) ? "R4" : "R8", "pc_inc pulses", pulses, (cls == 2'd2) ? 2 : 1);
  endtask

  task automatic test_reset;
    #1;
    check_idle("R1");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1");
  endtask

  task automatic test_mid_reset;
    @(negedge clk);
    iclass = 2'd3;
    start  = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    check("R11", "busy before reset", busy, 1);
    rst_n = 1'b0;
    #1;
    check_idle("R11");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R11");
  endtask

  initial begin
    #1000000;
    bad++;
    total++;
    $display("FAIL all watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    test_reset();
    run_instr(2'd0, 1'b0);
    run_instr(2'd1, 1'b0);
    run_instr(2'd2, 1'b0);
    run_instr(2'd3, 1'b0);
    run_instr(2'd2, 1'b1);
    run_instr(2'd3, 1'b1);
    test_mid_reset();
    run_instr(2'd1, 1'b0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule